// File: doc/BRIEF.md
# Error-Logging Control and Status Register

This block is one 32-bit control and status word that sits beside a bus interface able to check either parity or ECC. It holds two control bits. The first picks ECC checking over parity checking. The second makes the checker treat correctable single-bit errors as uncorrectable. Software can change these two bits only by setting a write-only update-enable bit in the same write data. Any write without that bit leaves both controls as they were. At reset the mode bit takes the value of a strap input, which is 1 when the bus trained into its high-speed second mode.

The word also logs the first failing transaction that the bus error detector reports. It keeps the error phase and the three command/attribute nibbles exactly as they appeared on the bus, before any correction. While a logged phase is non-zero, capture is frozen. Reading the word clears the phase field, and that re-arms capture. The command nibbles keep their last values but are then no longer valid.

Top module: `errlog_csr`

## Requirements
- R1: While `rst` is high at a clock edge, bit 31 loads the value of `strap_mode2`, and bit 30, the capture nibbles and the phase field load 0.
- R2: Output `ecc_mode` equals bit 31 of `rdata` (1 = ECC checking, 0 = parity checking).
- R3: A write (`wr_en` high) whose `wdata[28]` is 1 loads `wdata[31]` into bit 31 and `wdata[30]` into bit 30, visible from the next cycle.
- R4: A write whose `wdata[28]` is 0 leaves bits 31 and 30 unchanged.
- R5: Bits 29 and 28 of `rdata` always read 0, and so do bits 15 down to PHASE_W.
- R6: `single_as_uncorr` is 1 exactly when bit 31 and bit 30 are both 1. In parity mode it is 0 whatever bit 30 holds.
- R7: When `err_valid` is high, `err_phase` is non-zero and the logged phase is 0, the next cycle shows `err_attr` in bits 27:24, `err_cmd2` in bits 23:20, `err_cmd1` in bits 19:16 and `err_phase` in bits PHASE_W-1:0, unaltered.
- R8: While the logged phase is non-zero, a new error event changes none of bits 27:16 or the phase field.
- R9: A cycle with `rd_en` high returns the current phase in `rdata`. From the next cycle the phase field is 0, while bits 27:16 keep their values.
- R10: After the phase field is cleared, the next error event is captured as in R7.
- R11: Writes never change bits 27:16 or the phase field.
- R12: An error event with `err_phase` equal to 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_mode2 | input | 1 | Strap: bus trained into the second high-speed mode; sampled during reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe; clears the phase field |
| rdata | output | 32 | Current register contents |
| err_valid | input | 1 | Error event from the bus error detector |
| err_phase | input | PHASE_W | Phase in which the error occurred (0 = none) |
| err_attr | input | 4 | Raw command/byte-enable nibble of the attribute phase |
| err_cmd2 | input | 4 | Raw command nibble of the second address phase |
| err_cmd1 | input | 4 | Raw command nibble of the first or only address phase |
| ecc_mode | output | 1 | 1 = ECC checking, 0 = parity checking |
| single_as_uncorr | output | 1 | Handle correctable errors as uncorrectable |

## Verification
The bench builds the block with PHASE_W = 3 rather than the default 4. This leaves bits 15:3 as unused read-zero bits, so a phase field that spills into them shows up in R5 checks. It also lets the bench log phase codes up to 7 and confirm they are stored unaltered. Both strap values are applied across separate resets, so the mode bit is seen to come from the strap and not from a constant.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

    localparam int CSR_W      = 32;
    localparam int NIB_W      = 4;
    localparam int LOW_W      = 16;
    localparam int MODE_BIT   = 31;
    localparam int DIS_BIT    = 30;
    localparam int UPD_BIT    = 28;

    typedef struct packed {
        logic mode;
        logic dis;
    } ctl_t;

    typedef struct packed {
        logic [NIB_W-1:0] attr;
        logic [NIB_W-1:0] cmd2;
        logic [NIB_W-1:0] cmd1;
    } log_t;

    function automatic logic [CSR_W-1:0] pack_csr(ctl_t c, log_t l, logic [LOW_W-1:0] ph);
        return {c.mode, c.dis, 2'b00, l.attr, l.cmd2, l.cmd1, ph};
    endfunction

endpackage

// File: rtl/errlog_ctl.sv
module errlog_ctl
    import errlog_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             strap_mode2,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wdata,
    output ctl_t             ctl
);

    logic upd;
    assign upd = wr_en && wdata[UPD_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl.mode <= strap_mode2;
            ctl.dis  <= 1'b0;
        end else if (upd) begin
            ctl.mode <= wdata[MODE_BIT];
            ctl.dis  <= wdata[DIS_BIT];
        end
    end

    // R3
    ctl_update_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> (ctl.mode == $past(wdata[MODE_BIT])) && (ctl.dis == $past(wdata[DIS_BIT])));

    // R4
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(ctl));

endmodule

// File: rtl/errlog_capture.sv
module errlog_capture
    import errlog_pkg::*;
#(
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic               err_valid,
    input  logic [PHASE_W-1:0] err_phase,
    input  log_t               err_log,
    output log_t               log_q,
    output logic [PHASE_W-1:0] phase_q
);

    logic armed;
    logic load;

    assign armed = (phase_q == '0);
    assign load  = err_valid && (err_phase != '0) && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            log_q   <= '0;
            phase_q <= '0;
        end else if (load) begin
            log_q   <= err_log;
            phase_q <= err_phase;
        end else if (rd_en) begin
            phase_q <= '0;
        end
    end

    // R7
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        (err_valid && err_phase != '0 && phase_q == '0)
        |=> (phase_q == $past(err_phase)) && (log_q == $past(err_log)));

    // R8
    capture_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != '0 && !rd_en) |=> $stable(phase_q) && $stable(log_q));

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && phase_q != '0) |=> (phase_q == '0) && $stable(log_q));

    // R12
    zero_phase_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == '0 && (!err_valid || err_phase == '0)) |=> (phase_q == '0) && $stable(log_q));

endmodule

// File: rtl/errlog_csr.sv
module errlog_csr
    import errlog_pkg::*;
#(
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strap_mode2,
    input  logic               wr_en,
    input  logic [31:0]        wdata,
    input  logic               rd_en,
    output logic [31:0]        rdata,
    input  logic               err_valid,
    input  logic [PHASE_W-1:0] err_phase,
    input  logic [3:0]         err_attr,
    input  logic [3:0]         err_cmd2,
    input  logic [3:0]         err_cmd1,
    output logic               ecc_mode,
    output logic               single_as_uncorr
);

    ctl_t               ctl;
    log_t               err_log;
    log_t               log_q;
    logic [PHASE_W-1:0] phase_q;
    logic [LOW_W-1:0]   phase_ext;

    assign err_log = '{attr: err_attr, cmd2: err_cmd2, cmd1: err_cmd1};

    errlog_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .strap_mode2 (strap_mode2),
        .wr_en       (wr_en),
        .wdata       (wdata),
        .ctl         (ctl)
    );

    errlog_capture #(.PHASE_W(PHASE_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .err_valid (err_valid),
        .err_phase (err_phase),
        .err_log   (err_log),
        .log_q     (log_q),
        .phase_q   (phase_q)
    );

    generate
        if (PHASE_W < LOW_W) begin : g_pad
            assign phase_ext = {{(LOW_W-PHASE_W){1'b0}}, phase_q};
        end else begin : g_full
            assign phase_ext = phase_q[LOW_W-1:0];
        end
    endgenerate

    assign rdata            = pack_csr(ctl, log_q, phase_ext);
    assign ecc_mode         = ctl.mode;
    assign single_as_uncorr = ctl.mode && ctl.dis;

    // R6
    parity_ignores_dis_chk: assert property (@(posedge clk) disable iff (rst)
        !rdata[MODE_BIT] |-> !single_as_uncorr);

    // R11
    write_keeps_log_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !err_valid && !rd_en) |=> $stable(rdata[27:0]));

endmodule

// File: tb/test_errlog_csr.sv
module test_errlog_csr;

    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          strap_mode2;
    logic          wr_en;
    logic [31:0]   wdata;
    logic          rd_en;
    logic [31:0]   rdata;
    logic          err_valid;
    logic [PW-1:0] err_phase;
    logic [3:0]    err_attr, err_cmd2, err_cmd1;
    logic          ecc_mode, single_as_uncorr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    errlog_csr #(.PHASE_W(PW)) i_errlog_csr (
        .clk(clk), .rst(rst), .strap_mode2(strap_mode2),
        .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
        .err_valid(err_valid), .err_phase(err_phase),
        .err_attr(err_attr), .err_cmd2(err_cmd2), .err_cmd1(err_cmd1),
        .ecc_mode(ecc_mode), .single_as_uncorr(single_as_uncorr)
    );

    // {w31, w30, w28, exp31, exp30}, starting from mode=0 dis=0
    localparam logic [4:0] VEC [8] = '{
        5'b111_11, 5'b000_11, 5'b011_01, 5'b100_01,
        5'b101_10, 5'b010_10, 5'b001_00, 5'b110_00
    };

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic do_reset(logic strap);
        @(negedge clk);
        rst = 1'b1; strap_mode2 = strap;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0; strap_mode2 = ~strap;
        @(negedge clk);
    endtask

    task automatic do_write(logic [31:0] d);
        wr_en = 1'b1; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic do_error(logic [PW-1:0] ph, logic [3:0] a, logic [3:0] c2, logic [3:0] c1);
        err_valid = 1'b1; err_phase = ph; err_attr = a; err_cmd2 = c2; err_cmd1 = c1;
        @(negedge clk);
        err_valid = 1'b0; err_phase = '0; err_attr = '0; err_cmd2 = '0; err_cmd1 = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; strap_mode2 = 1'b0; wr_en = 1'b0; wdata = '0; rd_en = 1'b0;
        err_valid = 1'b0; err_phase = '0; err_attr = '0; err_cmd2 = '0; err_cmd1 = '0;

        // R1 reset with strap 0
        do_reset(1'b0);
        check("R1 reset strap0", rdata, 32'h0000_0000);
        check("R2 ecc_mode after strap0", {31'b0, ecc_mode}, 32'd0);

        // R3 R4 R6 R5 table walk
        for (int i = 0; i < 8; i++) begin
            logic [4:0] v;
            v = VEC[i];
            do_write({v[4], v[3], 1'b0, v[2], 28'hFFF_FFFF});
            check("R3/R4 ctl bits", {30'b0, rdata[31:30]}, {30'b0, v[1:0]});
            check("R5 reserved/upd read zero", {28'b0, rdata[29:28], rdata[15:14]}, 32'd0);
            check("R6 single_as_uncorr", {31'b0, single_as_uncorr}, {31'b0, v[1] & v[0]});
            check("R2 ecc_mode", {31'b0, ecc_mode}, {31'b0, v[1]});
            check("R11 write leaves log", {4'b0, rdata[27:0]}, 32'd0);
        end

        // R6 parity mode ignores disable bit
        do_write(32'h5000_0000);
        check("R6 parity ignores dis", {30'b0, single_as_uncorr, rdata[30]}, 32'd1);

        // R1 reset with strap 1
        do_reset(1'b1);
        check("R1 reset strap1", rdata, 32'h8000_0000);

        // R12 zero-phase event ignored
        do_error(3'd0, 4'h9, 4'h9, 4'h9);
        check("R12 zero phase ignored", rdata, 32'h8000_0000);

        // R7 capture
        do_error(3'd6, 4'hA, 4'h5, 4'hC);
        check("R7 capture", rdata, 32'h8A5C_0006);

        // R8 second error does not overwrite
        do_error(3'd2, 4'h1, 4'h2, 4'h3);
        check("R8 no overwrite", rdata, 32'h8A5C_0006);

        // R11 write does not touch log
        do_write(32'hFFFF_FFFF);
        check("R11 write keeps log", rdata, 32'hCA5C_0006);

        // R9 read returns phase then clears it
        rd_en = 1'b1;
        #1;
        check("R9 read returns phase", {29'b0, rdata[2:0]}, 32'd6);
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 phase cleared, nibbles kept", rdata, 32'hCA5C_0000);

        // R10 re-armed capture
        do_error(3'd7, 4'h3, 4'hE, 4'h1);
        check("R10 recapture", rdata, 32'hC3E1_0007);
        check("R5 bits above phase zero", {16'b0, rdata[15:0]}, 32'd7);

        done = 1'b1;
        finish_run();
    end

endmodule